// File: doc/BRIEF.md
# Dual-Suffix Serial Pattern Detector

The block watches a serial bit stream, one bit per clock when the qualifier is high, and raises a detect pulse in the same cycle as the bit that makes the recent history end in either `110` or `0101`. Both patterns are tracked by one merged machine of six states, so a bit that finishes one match can also start or continue the next. This holds for repeats of the same pattern and for a `0101` match running into a `110` match.

The detect output is a Mealy output. It is decoded from the present state and the incoming bit, so it appears in the cycle that completes the pattern, with no added latency. A second output tells which pattern fired. The present state code is also brought out for observation. Cycles with the qualifier low do not advance the machine. Reset is synchronous.

Top module: `seqdet_dual`

## Requirements
- R1: While `rst` is high at a rising edge the state becomes code 0 (nothing seen). `det_o` and `pat_o` are 0 during any cycle in which `rst` is high.
- R2: In a cycle with `vld_i` low, `det_o` and `pat_o` are 0, and the state at the next edge equals the current state, whatever `bit_i` is.
- R3: When a valid bit completes the suffix `110`, `det_o` is 1 in that same cycle and `pat_o` is 0.
- R4: When a valid bit completes the suffix `0101`, `det_o` is 1 in that same cycle and `pat_o` is 1.
- R5: Matches overlap. In `0101` followed by `01`, both the fourth and the sixth bit detect. In `0110` the last bit detects as `110`.
- R6: Suffixes that match neither pattern give no detect. Examples are `011`, `111`, `000` and `0100`.
- R7: The state code on `state_o` has six legal values. The codes are 0 = start, 1 = last bit 0, 2 = a single 1 from start, 3 = ends `01`, 4 = ends `11`, 5 = ends `010`. After each valid bit the code moves to the state that describes the new history.
- R8: `pat_o` is 1 only when `det_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| vld_i | input | 1 | Bit qualifier: `bit_i` is consumed this cycle |
| bit_i | input | 1 | Serial data bit |
| det_o | output | 1 | Detect pulse, combinational, same cycle as the completing bit |
| pat_o | output | 1 | 1 = `0101` matched, 0 = `110` matched or no detect |
| state_o | output | 3 | Present state code (see R7) |

## Verification
The bench walks a long stream in which matches chain back to back. A design that reset its history after each hit would miss the second `0101` and the `110` that ends `0110`. The stream includes `011` and a run of 1s. A machine that flagged the `01` state on a further 1 would pulse there falsely. Idle cycles are placed while a match is one bit away, and a reset is raised while the incoming bit would complete `110`. A design that let the machine advance on an idle cycle, or did not gate the Mealy output with reset, would show a pulse or a state move at that point.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

    localparam int SD_STW = 3;

    // Codes carry meaning (see brief, R7): they are visible on state_o.
    typedef enum logic [SD_STW-1:0] {
        SD_START = 3'd0,
        SD_Z     = 3'd1,
        SD_ONE   = 3'd2,
        SD_ZO    = 3'd3,
        SD_OO    = 3'd4,
        SD_ZOZ   = 3'd5
    } sd_state_e;

    typedef struct packed {
        sd_state_e st;
    } sd_regs_t;

endpackage

// File: rtl/seqdet_step.sv
module seqdet_step
    import seqdet_pkg::*;
(
    input  sd_state_e st_i,
    input  logic      bit_i,
    output sd_state_e nxt_o
);

    always_comb begin
        unique case (st_i)
            SD_START: nxt_o = bit_i ? SD_ONE : SD_Z;
            SD_Z:     nxt_o = bit_i ? SD_ZO  : SD_Z;
            SD_ONE:   nxt_o = bit_i ? SD_OO  : SD_Z;
            SD_ZO:    nxt_o = bit_i ? SD_OO  : SD_ZOZ;
            SD_OO:    nxt_o = bit_i ? SD_OO  : SD_Z;
            SD_ZOZ:   nxt_o = bit_i ? SD_ZO  : SD_Z;
            default:  nxt_o = SD_START;
        endcase
    end

endmodule

// File: rtl/seqdet_flag.sv
module seqdet_flag
    import seqdet_pkg::*;
(
    input  sd_state_e st_i,
    input  logic      bit_i,
    input  logic      en_i,
    output logic      hit_o,
    output logic      alt_o
);

    logic hit_110;
    logic hit_0101;

    always_comb begin
        hit_110  = (st_i == SD_OO)  && !bit_i;
        hit_0101 = (st_i == SD_ZOZ) &&  bit_i;
        hit_o    = en_i && (hit_110 || hit_0101);
        alt_o    = en_i && hit_0101;
    end

endmodule

// File: rtl/seqdet_dual.sv
module seqdet_dual
    import seqdet_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              vld_i,
    input  logic              bit_i,
    output logic              det_o,
    output logic              pat_o,
    output logic [SD_STW-1:0] state_o
);

    sd_regs_t  regs_d;
    sd_regs_t  regs_q;
    sd_state_e step_nxt;
    logic      flag_en;

    seqdet_step u_step (
        .st_i  (regs_q.st),
        .bit_i (bit_i),
        .nxt_o (step_nxt)
    );

    assign flag_en = vld_i && !rst;

    seqdet_flag u_flag (
        .st_i  (regs_q.st),
        .bit_i (bit_i),
        .en_i  (flag_en),
        .hit_o (det_o),
        .alt_o (pat_o)
    );

    always_comb begin
        regs_d = regs_q;
        if (vld_i) begin
            regs_d.st = step_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q.st <= SD_START;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign state_o = regs_q.st;

endmodule

// File: rtl/seqdet_dual_chk.sv
module seqdet_dual_chk (
    input logic       clk,
    input logic       rst,
    input logic       vld_i,
    input logic       bit_i,
    input logic       det_o,
    input logic       pat_o,
    input logic [2:0] state_o
);

    logic rst_seen_q;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
    end

    // R1: one edge after reset the start code is visible
    always @(posedge clk) begin
        if (rst_seen_q === 1'b1) begin
            a_r1_reset_to_start: assert (state_o == 3'd0);
        end
    end

    // R2: idle cycles leave the state alone
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> $stable(state_o));

    // R2: idle cycles never detect
    a_r2_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !vld_i |-> !det_o && !pat_o);

    // R3: a 110 hit leaves the machine in the trailing-zero state
    a_r3_after_110: assert property (@(posedge clk) disable iff (rst)
        (det_o && !pat_o) |=> state_o == 3'd1);

    // R4: a 0101 hit leaves the machine in the ends-01 state
    a_r4_after_0101: assert property (@(posedge clk) disable iff (rst)
        (det_o && pat_o) |=> state_o == 3'd3);

    // R7: only six codes are reachable
    a_r7_legal_code: assert property (@(posedge clk) disable iff (rst)
        state_o <= 3'd5);

    // R7: a 1 after a lone 0 reaches the ends-01 state
    a_r7_zero_one: assert property (@(posedge clk) disable iff (rst)
        (vld_i && bit_i && state_o == 3'd1) |=> state_o == 3'd3);

    // R8: pattern flag only with a detect
    a_r8_pat_needs_det: assert property (@(posedge clk) disable iff (rst)
        pat_o |-> det_o);

endmodule

bind seqdet_dual seqdet_dual_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .vld_i   (vld_i),
    .bit_i   (bit_i),
    .det_o   (det_o),
    .pat_o   (pat_o),
    .state_o (state_o)
);

// File: tb/sim_seqdet_dual.sv
`timescale 1ns/1ps
module sim_seqdet_dual;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       vld_i = 1'b0;
    logic       bit_i = 1'b0;
    logic       det_o;
    logic       pat_o;
    logic [2:0] state_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    seqdet_dual u0 (
        .clk     (clk),
        .rst     (rst),
        .vld_i   (vld_i),
        .bit_i   (bit_i),
        .det_o   (det_o),
        .pat_o   (pat_o),
        .state_o (state_o)
    );

    // entry: {vld, bit, exp_det, exp_pat, exp_next_state[2:0]}
    localparam int NV = 25;
    localparam logic [6:0] VEC [NV] = '{
        7'b1_1_0_0_010, // 1    -> one
        7'b1_1_0_0_100, // 11   -> R7
        7'b1_0_1_0_001, // 110  R3
        7'b1_1_0_0_011, // 01
        7'b1_0_0_0_101, // 010
        7'b0_1_0_0_101, // idle, R2
        7'b1_1_1_1_011, // 0101 R4
        7'b1_0_0_0_101, // 010
        7'b1_1_1_1_011, // 0101 again R5
        7'b1_1_0_0_100, // 011 R6
        7'b1_0_1_0_001, // 0110 R5
        7'b1_0_0_0_001, // 00
        7'b1_1_0_0_011, // 001
        7'b1_1_0_0_100, // 011 R6
        7'b0_0_0_0_100, // idle with would-be 110, R2
        7'b1_1_0_0_100, // 111 R6
        7'b1_0_1_0_001, // 110 R3
        7'b1_1_0_0_011,
        7'b1_0_0_0_101,
        7'b1_0_0_0_001, // 0100 R6
        7'b1_1_0_0_011,
        7'b1_0_0_0_101,
        7'b1_1_1_1_011, // 0101 R4
        7'b1_1_0_0_100,
        7'b1_0_1_0_001  // 10110 -> 110 R3
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic b, input int edet,
                        input int epat, input int est, input string req);
        @(negedge clk);
        vld_i = v;
        bit_i = b;
        #1;
        check({req, " det"}, int'(det_o), edet);
        check({req, " pat"}, int'(pat_o), epat);
        @(posedge clk);
        #1;
        check({req, " state"}, int'(state_o), est);
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 reset state", int'(state_o), 0);
        check("R1 reset det", int'(det_o), 0);
        @(negedge clk);
        rst = 1'b0;

        // table walk
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][6], VEC[i][5], int'(VEC[i][4]), int'(VEC[i][3]),
                 int'(VEC[i][2:0]), $sformatf("R7 vec%0d", i));
        end

        // R4 R5: 0101 right after reset, then 01 overlap
        @(negedge clk); rst = 1'b1; @(posedge clk); #1;
        check("R1 reset mid-stream", int'(state_o), 0);
        @(negedge clk); rst = 1'b0;
        step(1'b1, 1'b0, 0, 0, 1, "R4");
        step(1'b1, 1'b1, 0, 0, 3, "R4");
        step(1'b1, 1'b0, 0, 0, 5, "R4");
        step(1'b1, 1'b1, 1, 1, 3, "R4 first");
        step(1'b1, 1'b0, 0, 0, 5, "R5");
        step(1'b1, 1'b1, 1, 1, 3, "R5 overlap");

        // R6: 000 from start gives nothing
        @(negedge clk); rst = 1'b1; @(posedge clk);
        @(negedge clk); rst = 1'b0;
        step(1'b1, 1'b0, 0, 0, 1, "R6 000");
        step(1'b1, 1'b0, 0, 0, 1, "R6 000");
        step(1'b1, 1'b0, 0, 0, 1, "R6 000");

        // R1: reset while the bit would complete 110
        step(1'b1, 1'b1, 0, 0, 3, "R1 prep");
        step(1'b1, 1'b1, 0, 0, 4, "R1 prep");
        @(negedge clk);
        rst = 1'b1; vld_i = 1'b1; bit_i = 1'b0;
        #1;
        check("R1 det gated by reset", int'(det_o), 0);
        check("R8 pat gated by reset", int'(pat_o), 0);
        @(posedge clk); #1;
        check("R1 state after reset", int'(state_o), 0);
        @(negedge clk); rst = 1'b0; vld_i = 1'b0;

        // R2: long idle with toggling data keeps state
        step(1'b1, 1'b1, 0, 0, 2, "R2 prep");
        for (int k = 0; k < 4; k++) begin
            step(1'b0, k[0], 0, 0, 2, "R2 idle");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule